// File: doc/BRIEF.md
# I2S Stereo Audio Receiver with Pair FIFO

This block takes a serial audio stream made of a bit clock, a word-select clock and one data line. It rebuilds each left word and each right word in separate shift registers. Each finished stereo pair is handed to the bus clock domain and stored in a 16-entry by 32-bit FIFO. A bus-side master drains the FIFO one entry per read pulse, left word first and then right word. Status outputs report when the FIFO is empty and when a pair was lost because the FIFO had no room.

The serial side works on the rising edge of the bit clock. The bit framing can be set for standard I2S, where data lags the word-select edge by one bit clock, or for a framing with no lag. The bit order can be MSB first or LSB first. The sample can sit at the start of the slot or at the end of the slot. Capture starts only when both a global enable and a channel enable are set. It then waits for a fresh left-word boundary, so a pair is never built from a partial word. A pair crosses clock domains as one unit by a toggle handshake, and it is written into the FIFO as two entries in one bus cycle.

Top module: `i2s_stereo_rx`

## Requirements
- R1: No pair is ever written unless `glb_en` and `ch_en` are both high. If either one is low, the FIFO stays empty however much serial data arrives.
- R2: After the enables are raised, any word already in progress is discarded. The first captured pair is the one whose left word starts at the next word-select transition to left (`lrck` low = left, `lrck` high = right).
- R3: `sdata` is sampled on rising `sclk`. With `i2s_fmt`=1, the first bit of a word arrives one bit clock after the `lrck` transition. With `i2s_fmt`=0, it arrives in the same bit clock as the transition.
- R4: A slot may be longer than the SW-bit sample. With `right_just`=0, the sample is the first SW bits of the slot. With `right_just`=1, the sample is the last SW bits of the slot. All other slot bits are ignored. A slot holds at least SW bits.
- R5: With `msb_first`=1, the first sample bit received is sample bit SW-1. With `msb_first`=0, the first sample bit received is sample bit 0.
- R6: A pair is committed when the next left word starts. It is stored as two entries, left and then right, each with the sample zero-extended in the low SW bits. Pairs leave in arrival order. `rd_data` always shows the oldest entry, and each `rd_en` pulse on a rising `pclk` removes that entry.
- R7: The FIFO holds 8 pairs. A pair that arrives when fewer than two entries are free is dropped whole and sets `overflow`. `overflow` stays high until `ovf_clr` is pulsed. If a drop and a clear happen in the same cycle, the flag is set.
- R8: `fifo_empty` is high after reset, falls once the first pair is stored, and rises again when every entry has been read. While the FIFO is empty, `rd_data` is zero and `rd_en` has no effect on later read order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| prst_n | input | 1 | Asynchronous active-low reset for both domains |
| sclk | input | 1 | Serial bit clock |
| lrck | input | 1 | Word select, low = left word |
| sdata | input | 1 | Serial data |
| glb_en | input | 1 | Global enable |
| ch_en | input | 1 | Channel enable |
| i2s_fmt | input | 1 | 1 = one-bit data delay after the word-select edge |
| msb_first | input | 1 | 1 = most significant bit received first |
| right_just | input | 1 | 1 = sample occupies the end of the slot |
| rd_en | input | 1 | Pop the oldest FIFO entry |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_data | output | 32 | Oldest FIFO entry, zero when empty |
| fifo_empty | output | 1 | FIFO holds no entries |
| overflow | output | 1 | Sticky: a pair was dropped |

## Verification
The hardest conditions to reach from the ports are the dropped pair and the discarded partial word at enable. For the drop, the stimulus streams ten back-to-back pairs without reading. This fills all eight slots and then forces two drops. The bench checks that exactly the first eight pairs come out, in order. For the partial word, the enables rise in the middle of a lead frame whose slot bits are all ones. This garbage would show up at the head of the FIFO if the receiver armed too early. Slots of 20 bits carry 16-bit samples and have ones in the padding bits. Any mistake in justification or bit order therefore corrupts the value that is read back. All eight framing, order and justification settings are swept this way.

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx #(
  parameter int SW    = 16,
  parameter int DEPTH = 16,
  parameter int FW    = 32
) (
  input  logic          pclk,
  input  logic          prst_n,
  input  logic          sclk,
  input  logic          lrck,
  input  logic          sdata,
  input  logic          glb_en,
  input  logic          ch_en,
  input  logic          i2s_fmt,
  input  logic          msb_first,
  input  logic          right_just,
  input  logic          rd_en,
  input  logic          ovf_clr,
  output logic [FW-1:0] rd_data,
  output logic          fifo_empty,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(FW + 1);

  // serial clock domain
  logic [1:0]    en_sync;
  logic          lr_d, ws_q, armed, have_left, tog;
  logic [CW-1:0] bcnt;
  logic [SW-1:0] lsh, rsh, lhold, pair_l, pair_r;

  wire en_s    = en_sync[1];
  wire ws_now  = i2s_fmt ? lr_d : lrck;
  wire ws_edge = ws_now ^ ws_q;
  wire take    = right_just || (bcnt < CW'(SW));

  function automatic logic [SW-1:0] shin(input logic [SW-1:0] sh, input logic b,
                                         input logic first, input logic msb);
    logic [SW-1:0] base;
    base = first ? '0 : sh;
    return msb ? {base[SW-2:0], b} : {b, base[SW-1:1]};
  endfunction

  always_ff @(posedge sclk or negedge prst_n) begin
    if (!prst_n) begin
      en_sync   <= '0;
      lr_d      <= 1'b0;
      ws_q      <= 1'b0;
      armed     <= 1'b0;
      have_left <= 1'b0;
      tog       <= 1'b0;
      bcnt      <= '0;
      lsh       <= '0;
      rsh       <= '0;
      lhold     <= '0;
      pair_l    <= '0;
      pair_r    <= '0;
    end else begin
      en_sync <= {en_sync[0], glb_en & ch_en};
      lr_d    <= lrck;
      ws_q    <= ws_now;
      if (!en_s) begin
        armed     <= 1'b0;
        have_left <= 1'b0;
      end else if (ws_edge) begin
        bcnt <= CW'(1);
        if (!ws_now) begin
          armed     <= 1'b1;
          lsh       <= shin(lsh, sdata, 1'b1, msb_first);
          have_left <= 1'b0;
          if (armed && have_left) begin
            pair_l <= lhold;
            pair_r <= rsh;
            tog    <= ~tog;
          end
        end else begin
          rsh <= shin(rsh, sdata, 1'b1, msb_first);
          if (armed) begin
            lhold     <= lsh;
            have_left <= 1'b1;
          end
        end
      end else begin
        if (bcnt != '1) bcnt <= bcnt + CW'(1);
        if (take) begin
          if (ws_now) rsh <= shin(rsh, sdata, 1'b0, msb_first);
          else        lsh <= shin(lsh, sdata, 1'b0, msb_first);
        end
      end
    end
  end

  a_r2_pair_needs_arm: assert property (@(posedge sclk) disable iff (!prst_n)
    (tog != $past(tog)) |-> $past(armed));
  a_r1_disable_disarms: assert property (@(posedge sclk) disable iff (!prst_n)
    !en_s |=> !armed);

  // bus clock domain
  logic [2:0]    tsync;
  logic [FW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          ovf;

  wire push_evt = tsync[2] ^ tsync[1];
  wire room     = cnt <= (AW+1)'(DEPTH - 2);
  wire do_wr    = push_evt && room;
  wire do_rd    = rd_en && (cnt != '0);

  always_ff @(posedge pclk) begin
    if (do_wr) begin
      mem[wp]          <= FW'(pair_l);
      mem[wp + AW'(1)] <= FW'(pair_r);
    end
  end

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      tsync <= '0;
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
    end else begin
      tsync <= {tsync[1:0], tog};
      if (do_wr) wp <= wp + AW'(2);
      if (do_rd) rp <= rp + AW'(1);
      cnt <= cnt + (do_wr ? (AW+1)'(2) : '0) - (do_rd ? (AW+1)'(1) : '0);
      if (push_evt && !room) ovf <= 1'b1;
      else if (ovf_clr)      ovf <= 1'b0;
    end
  end

  assign fifo_empty = (cnt == '0);
  assign rd_data    = fifo_empty ? '0 : mem[rp];
  assign overflow   = ovf;

  a_r7_bounded: assert property (@(posedge pclk) disable iff (!prst_n)
    cnt <= (AW+1)'(DEPTH));
  a_r7_ovf_sticky: assert property (@(posedge pclk) disable iff (!prst_n)
    (overflow && !ovf_clr) |=> overflow);
  a_r7_drop_whole: assert property (@(posedge pclk) disable iff (!prst_n)
    (push_evt && !room) |=> $stable(wp));
  a_r8_empty_pop_inert: assert property (@(posedge pclk) disable iff (!prst_n)
    (fifo_empty && rd_en) |=> $stable(rp));
  a_r8_empty_clears: assert property (@(posedge pclk) disable iff (!prst_n)
    do_wr |=> !fifo_empty);
endmodule

// File: tb/i2s_stereo_rx_bench.sv
module i2s_stereo_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SB_HALF    = 40;
  localparam int SW         = 16;
  localparam int SLOT       = 20;

  logic pclk = 0, prst_n = 0, sclk = 0, lrck = 0, sdata = 0;
  logic glb_en = 0, ch_en = 0, i2s_fmt = 0, msb_first = 0, right_just = 0;
  logic rd_en = 0, ovf_clr = 0;
  logic [31:0] rd_data;
  logic fifo_empty, overflow;

  int checks = 0, errors = 0;
  logic prevbit;
  logic [SW-1:0] el [12];
  logic [SW-1:0] er [12];

  i2s_stereo_rx #(.SW(SW), .DEPTH(16), .FW(32)) u_i2s_stereo_rx (
    .pclk(pclk), .prst_n(prst_n), .sclk(sclk), .lrck(lrck), .sdata(sdata),
    .glb_en(glb_en), .ch_en(ch_en), .i2s_fmt(i2s_fmt), .msb_first(msb_first),
    .right_just(right_just), .rd_en(rd_en), .ovf_clr(ovf_clr),
    .rd_data(rd_data), .fifo_empty(fifo_empty), .overflow(overflow));

  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic wbit(input logic [SW-1:0] v, input int i);
    int k;
    if (right_just) begin
      if (i < SLOT - SW) return 1'b1;
      k = i - (SLOT - SW);
    end else begin
      if (i >= SW) return 1'b1;
      k = i;
    end
    return msb_first ? v[SW-1-k] : v[k];
  endfunction

  task automatic send_bit(input logic ws, input logic b);
    lrck  = ws;
    sdata = i2s_fmt ? prevbit : b;
    prevbit = b;
    #SB_HALF sclk = 1;
    #SB_HALF sclk = 0;
  endtask

  task automatic stream(input int n, input logic g, input logic c);
    prevbit = 1'b1;
    for (int i = 0; i < SLOT; i++) begin
      if (i == 5) begin glb_en = g; ch_en = c; end
      send_bit(1'b0, 1'b1);
    end
    for (int i = 0; i < SLOT; i++) send_bit(1'b1, 1'b1);
    for (int f = 0; f < n; f++) begin
      for (int i = 0; i < SLOT; i++) send_bit(1'b0, wbit(el[f], i));
      for (int i = 0; i < SLOT; i++) send_bit(1'b1, wbit(er[f], i));
    end
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b1);
    glb_en = 0; ch_en = 0;
    for (int i = 0; i < 4; i++) send_bit(1'b0, 1'b0);
    repeat (8) @(negedge pclk);
  endtask

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      el[k] = SW'(seed * 16'h2F1 + k * 16'h4B7 + 16'h1234);
      er[k] = ~el[k] ^ SW'(k * 16'h0101 + seed);
    end
  endtask

  task automatic pop;
    @(negedge pclk) rd_en = 1;
    @(negedge pclk) rd_en = 0;
  endtask

  task automatic drain(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(req, rd_data, {16'h0, el[k]});
      pop();
      check(req, rd_data, {16'h0, er[k]});
      pop();
    end
    check("R8 empty after drain", {31'b0, fifo_empty}, 32'd1);
    check("R8 zero when empty", rd_data, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge pclk);
    prst_n = 1;
    @(negedge pclk);
    check("R8 reset empty", {31'b0, fifo_empty}, 32'd1);
    check("R7 reset overflow", {31'b0, overflow}, 32'd0);
    check("R8 reset data", rd_data, 32'd0);

    fill(2, 7);
    stream(2, 1'b1, 1'b0);
    check("R1 channel enable low", {31'b0, fifo_empty}, 32'd1);
    stream(2, 1'b0, 1'b1);
    check("R1 global enable low", {31'b0, fifo_empty}, 32'd1);

    for (int cfg = 0; cfg < 8; cfg++) begin
      i2s_fmt = cfg[0]; msb_first = cfg[1]; right_just = cfg[2];
      fill(3, cfg + 1);
      check("R8 empty before stream", {31'b0, fifo_empty}, 32'd1);
      stream(3, 1'b1, 1'b1);
      check("R8 not empty after pair", {31'b0, fifo_empty}, 32'd0);
      check("R2 first pair skips partial lead", rd_data, {16'h0, el[0]});
      drain(3, "R3 R4 R5 R6 pair data");
    end

    i2s_fmt = 1; msb_first = 1; right_just = 0;
    pop();
    check("R8 empty read data", rd_data, 32'd0);
    check("R8 empty read flag", {31'b0, fifo_empty}, 32'd1);
    fill(1, 21);
    stream(1, 1'b1, 1'b1);
    drain(1, "R8 order after empty read");

    fill(10, 33);
    check("R7 overflow clear before", {31'b0, overflow}, 32'd0);
    stream(10, 1'b1, 1'b1);
    check("R7 overflow set", {31'b0, overflow}, 32'd1);
    drain(8, "R7 first eight pairs kept");
    check("R7 overflow sticky", {31'b0, overflow}, 32'd1);
    @(negedge pclk) ovf_clr = 1;
    @(negedge pclk) ovf_clr = 0;
    check("R7 overflow cleared", {31'b0, overflow}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule